// File: doc/BRIEF.md
# Shared-Pin Address/Data Bus Sequencer

This block sits between an 8-bit processor core and external memory that shares one group of sixteen pins for both address and data. Each processor request whose address lies at or above the top of a 4 KiB on-die RAM window becomes a short external transaction. The full 16-bit address is placed on the pins first, together with an address-latch pulse so that external latches can capture it. The data byte then moves over the low pins, written by the block or read back from memory. The block drives the pin direction, an address-latch strobe, a read strobe and a write strobe. All three strobes work at half-clock resolution and come straight from flip-flops: one set clocked on the rising edge and one on the falling edge. None of them is gated with the clock.

Requests below the window limit go to the on-die RAM port and never touch the pins. The processor holds a request until a one-cycle ready pulse comes back. A 2-bit setting chooses the write-strobe width, so asynchronous SRAM can be given a pulse shorter than a whole clock.

Half-cycles are numbered from the clock cycle after a request is accepted. Half 0 is the high phase of that cycle, half 1 its low phase, half 2 the high phase of the next cycle, and so on. Cycle k holds halves 2k and 2k+1.

Top module: `muxbus_ctrl`

## Requirements
- R1: In cycle 0 after an external request is accepted, `ad_oe` is 1 in both halves and `ad_o` carries the whole 16-bit request address.
- R2: `bus_ale` is 1 in half 0 only, and 0 in every other half.
- R3: For an external write, from cycle 1 up to the last transaction cycle `ad_oe` stays 1 and `ad_o` equals the data byte zero-extended to 16 bits.
- R4: The write strobe `bus_we` is 1 from half 3 for W halves, with W=1 for `cfg_we_width`=0, W=2 for 1, and W=3 for 2 and 3. One idle driven half lies before it and one after it inside the data phase. A write lasts 3 cycles for codes 0 and 1, and 4 cycles for codes 2 and 3.
- R5: For an external read, `ad_oe` is 0 from half 2 onward. Half 2 is a turnaround in which `bus_rd` is also 0. `bus_rd` is 1 in halves 3, 4 and 5. `ad_i` is captured at the rising edge that ends half 5, and the read lasts 3 cycles.
- R6: `cpu_ready` is a single-cycle pulse in the cycle after the last transaction cycle. For reads, `cpu_rdata` in that cycle holds the captured byte.
- R7: A request with address below 0x1000 asserts `iram_sel` and `cpu_ready` together in cycle 0. `iram_addr` (the low 12 address bits), `iram_we` and `iram_wdata` are valid in that cycle, `cpu_rdata` equals `iram_rdata`, and no strobe or `ad_oe` is raised.
- R8: A request with address 0x1000 or above never asserts `iram_sel`.
- R9: While `rst_n` is low, all strobes, `ad_oe`, `ad_o`, `cpu_ready` and `iram_sel` are 0.
- R10: The write-strobe setting is taken when the request is accepted. Changing `cfg_we_width` during a transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes change on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Request address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with ready |
| cfg_we_width | input | 2 | Write-strobe width code |
| iram_sel | output | 1 | On-die RAM access strobe |
| iram_we | output | 1 | On-die RAM write enable |
| iram_addr | output | 12 | On-die RAM byte address |
| iram_wdata | output | 8 | On-die RAM write byte |
| iram_rdata | input | 8 | On-die RAM read byte |
| ad_o | output | 16 | Shared pin output values |
| ad_oe | output | 1 | Shared pin output enable |
| ad_i | input | 8 | Low shared pins, input side |
| bus_ale | output | 1 | Address-latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_we | output | 1 | Write strobe |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data byte and a 4096-byte window. With these values the window edge at 0x0FFF/0x1000 and the top address 0xFFFF are exact, reachable stimulus. Every strobe is sampled in both halves of each cycle, so the half-cycle placement of the latch pulse, of all four write-width codes and of the read turnaround is checked directly. Some random transactions also change the width setting while a transaction is under way.

// File: rtl/muxbus_pkg.sv
// Shared constants, transaction descriptor and strobe-shape decoding for
// the shared-pin bus sequencer. Assumes half-cycle index = {cycle, phase}.
package muxbus_pkg;

    localparam int CYC_W  = 3;
    localparam int HALF_W = CYC_W + 1;
    localparam int NSTRB  = 3;
    localparam int S_ALE  = 0;
    localparam int S_WE   = 1;
    localparam int S_RD   = 2;

    // Latched description of an external transaction
    typedef struct packed {
        logic       wr;
        logic [1:0] wh;   // write-strobe width in half cycles, 1..3
    } xfer_t;

    // Width code to half cycles: 0 -> 1, 1 -> 2, 2 and 3 -> 3
    function automatic logic [1:0] we_halves(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd1;
            2'd1:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Index of the final cycle of a transaction
    function automatic logic [CYC_W-1:0] last_cycle(input xfer_t x);
        if (x.wr) return CYC_W'((5 + int'(x.wh)) / 2 - 1);
        return CYC_W'(2);
    endfunction

    // Strobe levels wanted during half h of a transaction
    function automatic logic [NSTRB-1:0] strobes_at(input logic [HALF_W-1:0] h,
                                                    input xfer_t x);
        logic [NSTRB-1:0] s;
        int hi;
        hi = int'(h);
        s = '0;
        s[S_ALE] = (hi == 0);
        s[S_WE]  = x.wr && (hi >= 3) && (hi <= 2 + int'(x.wh));
        s[S_RD]  = !x.wr && (hi >= 3) && (hi <= 5);
        return s;
    endfunction

endpackage

// File: rtl/muxbus_window.sv
// Address window decode: flags addresses that belong to the on-die RAM.
// Assumes the window starts at address zero and spans IRAM_BYTES bytes.
module muxbus_window #(
    parameter int ADDR_W     = 16,
    parameter int IRAM_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window
);
    // Compare against the window size as an unsigned integer
    assign in_window = (int'(addr) < IRAM_BYTES);
endmodule

// File: rtl/muxbus_halfstrobe.sv
// Half-cycle strobe built from one rising-edge and one falling-edge flop.
// Output is the XOR of the two; only one input of the XOR moves at a time,
// so the result is free of glitches. first_d/second_d give the levels for
// the two halves of the cycle that begins at the sampling rising edge.
module muxbus_halfstrobe (
    input  logic clk,
    input  logic rst_n,
    input  logic first_d,
    input  logic second_d,
    output logic strb
);
    logic rise_q, fall_q, second_q;

    // Rising edge: set the first-half level and remember the second-half one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q   <= 1'b0;
            second_q <= 1'b0;
        end else begin
            rise_q   <= first_d ^ fall_q;
            second_q <= second_d;
        end
    end

    // Falling edge: move the output to the stored second-half level
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b0;
        else        fall_q <= rise_q ^ second_q;
    end

    assign strb = rise_q ^ fall_q;
endmodule

// File: rtl/muxbus_seq.sv
// Transaction sequencer: accepts processor requests, serves window hits in
// one cycle, and steps external transactions cycle by cycle, producing the
// pin values, pin direction and per-half strobe levels for the next cycle.
// Assumes the processor holds its request until it sees ready.
module muxbus_seq
    import muxbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int IRAM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [1:0]        cfg_we_width,
    input  logic              in_window,
    input  logic [DATA_W-1:0] ad_i,
    input  logic [DATA_W-1:0] iram_rdata,
    output logic [NSTRB-1:0]  first_d,
    output logic [NSTRB-1:0]  second_d,
    output logic [ADDR_W-1:0] ad_o,
    output logic              ad_oe,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              iram_sel,
    output logic              iram_we,
    output logic [IRAM_AW-1:0] iram_addr,
    output logic [DATA_W-1:0] iram_wdata
);
    logic              busy_q, busy_d;
    logic [CYC_W-1:0]  cyc_q, cyc_d;
    xfer_t             x_q, x_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [DATA_W-1:0] data_q, data_d, rdata_q;
    logic              rdy_q, int_q, iwe_q, oe_q;
    logic [ADDR_W-1:0] ado_q;
    logic              accept, last;

    assign accept = !busy_q && !rdy_q && cpu_req;
    assign last   = busy_q && (cyc_q == last_cycle(x_q));
    assign addr_d = accept ? cpu_addr  : addr_q;
    assign data_d = accept ? cpu_wdata : data_q;

    // Next transaction state
    always_comb begin
        busy_d = busy_q;
        cyc_d  = cyc_q;
        x_d    = x_q;
        if (accept && !in_window) begin
            busy_d = 1'b1;
            cyc_d  = '0;
            x_d.wr = cpu_we;
            x_d.wh = we_halves(cfg_we_width);
        end else if (last) begin
            busy_d = 1'b0;
        end else if (busy_q) begin
            cyc_d = cyc_q + 1'b1;
        end
    end

    // Strobe levels for both halves of the coming cycle
    always_comb begin
        first_d  = busy_d ? strobes_at({cyc_d, 1'b0}, x_d) : '0;
        second_d = busy_d ? strobes_at({cyc_d, 1'b1}, x_d) : '0;
    end

    // State, pin and handshake registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cyc_q   <= '0;
            x_q     <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
            rdy_q   <= 1'b0;
            int_q   <= 1'b0;
            iwe_q   <= 1'b0;
            oe_q    <= 1'b0;
            ado_q   <= '0;
        end else begin
            busy_q <= busy_d;
            cyc_q  <= cyc_d;
            x_q    <= x_d;
            addr_q <= addr_d;
            data_q <= data_d;
            rdy_q  <= (accept && in_window) || last;
            int_q  <= accept && in_window;
            iwe_q  <= accept && in_window && cpu_we;
            if (last && !x_q.wr) rdata_q <= ad_i;
            oe_q   <= busy_d && ((cyc_d == '0) || x_d.wr);
            if (!busy_d)            ado_q <= '0;
            else if (cyc_d == '0)   ado_q <= addr_d;
            else if (x_d.wr)        ado_q <= ADDR_W'(data_d);
            else                    ado_q <= '0;
        end
    end

    assign ad_o       = ado_q;
    assign ad_oe      = oe_q;
    assign cpu_ready  = rdy_q;
    assign cpu_rdata  = int_q ? iram_rdata : rdata_q;
    assign iram_sel   = int_q;
    assign iram_we    = iwe_q;
    assign iram_addr  = addr_q[IRAM_AW-1:0];
    assign iram_wdata = data_q;
endmodule

// File: rtl/muxbus_ctrl.sv
// Top of the shared-pin bus sequencer: window decode, transaction sequencer
// and one glitch-free half-cycle strobe generator per bus strobe.
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int IRAM_BYTES = 4096
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic [ADDR_W-1:0]             cpu_addr,
    input  logic [DATA_W-1:0]             cpu_wdata,
    output logic                          cpu_ready,
    output logic [DATA_W-1:0]             cpu_rdata,
    input  logic [1:0]                    cfg_we_width,
    output logic                          iram_sel,
    output logic                          iram_we,
    output logic [$clog2(IRAM_BYTES)-1:0] iram_addr,
    output logic [DATA_W-1:0]             iram_wdata,
    input  logic [DATA_W-1:0]             iram_rdata,
    output logic [ADDR_W-1:0]             ad_o,
    output logic                          ad_oe,
    input  logic [DATA_W-1:0]             ad_i,
    output logic                          bus_ale,
    output logic                          bus_rd,
    output logic                          bus_we
);
    localparam int IRAM_AW = $clog2(IRAM_BYTES);

    logic             in_window;
    logic [NSTRB-1:0] first_d, second_d, strb;

    muxbus_window #(.ADDR_W(ADDR_W), .IRAM_BYTES(IRAM_BYTES)) u_window (
        .addr      (cpu_addr),
        .in_window (in_window)
    );

    muxbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRAM_AW(IRAM_AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cfg_we_width (cfg_we_width),
        .in_window    (in_window),
        .ad_i         (ad_i),
        .iram_rdata   (iram_rdata),
        .first_d      (first_d),
        .second_d     (second_d),
        .ad_o         (ad_o),
        .ad_oe        (ad_oe),
        .cpu_ready    (cpu_ready),
        .cpu_rdata    (cpu_rdata),
        .iram_sel     (iram_sel),
        .iram_we      (iram_we),
        .iram_addr    (iram_addr),
        .iram_wdata   (iram_wdata)
    );

    for (genvar g = 0; g < NSTRB; g++) begin : g_strb
        muxbus_halfstrobe u_hs (
            .clk      (clk),
            .rst_n    (rst_n),
            .first_d  (first_d[g]),
            .second_d (second_d[g]),
            .strb     (strb[g])
        );
    end

    assign bus_ale = strb[S_ALE];
    assign bus_we  = strb[S_WE];
    assign bus_rd  = strb[S_RD];
endmodule

// File: rtl/muxbus_ctrl_chk.sv
// Checker for the shared-pin bus sequencer, bound to every instance.
// Rising-edge sampling sees low-phase (second half) values; falling-edge
// sampling sees high-phase (first half) values.
module muxbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_ready,
    input logic iram_sel,
    input logic ad_oe,
    input logic bus_ale,
    input logic bus_rd,
    input logic bus_we
);
    // Latch strobe never present in a second half
    assert_ale_low_second_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ale);

    // Address is driven whenever the latch strobe is high
    assert_ale_with_drive_R1: assert property (@(negedge clk) disable iff (!rst_n)
        bus_ale |-> ad_oe);

    // Write strobe only while the pins are driven
    assert_we_driven_hi_R3: assert property (@(negedge clk) disable iff (!rst_n)
        bus_we |-> ad_oe);
    assert_we_driven_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ad_oe);

    // Read strobe only while the pins are released
    assert_rd_released_hi_R5: assert property (@(negedge clk) disable iff (!rst_n)
        bus_rd |-> !ad_oe);
    assert_rd_released_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !ad_oe);

    // Ready is a single-cycle pulse
    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // On-die RAM access completes at once and leaves the pins alone
    assert_iram_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iram_sel |-> (cpu_ready && !ad_oe));
endmodule

bind muxbus_ctrl muxbus_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .iram_sel  (iram_sel),
    .ad_oe     (ad_oe),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_we    (bus_we)
);

// File: tb/muxbus_ctrl_tb.sv
// Bench for the shared-pin bus sequencer: directed window-edge and width
// cases plus seeded random transactions, each compared half by half.
module muxbus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic [1:0]  cfg_we_width;
    logic        iram_sel, iram_we;
    logic [11:0] iram_addr;
    logic [7:0]  iram_wdata, iram_rdata;
    logic [15:0] ad_o;
    logic        ad_oe;
    logic [7:0]  ad_i;
    logic        bus_ale, bus_rd, bus_we;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [7:0] iram_model(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] ext_model(input logic [15:0] a);
        return (a[15:8] + {a[6:0], 1'b1}) ^ 8'hC3;
    endfunction

    assign iram_rdata = iram_model(iram_addr);

    muxbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .cfg_we_width(cfg_we_width), .iram_sel(iram_sel),
        .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
        .iram_rdata(iram_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_we(bus_we)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // Per-half records of one external transaction
    logic [9:0] ale_v, we_v, rd_v, oe_v;
    logic [4:0] rdy_v;
    logic       adr_bad, dat_bad, iram_seen;
    logic [7:0] got_rdata;

    task automatic grab(input int h, input logic [15:0] a, input logic [15:0] dv,
                        input bit wr, input int ncyc, input logic [7:0] rv);
        ale_v[h] = bus_ale;
        we_v[h]  = bus_we;
        rd_v[h]  = bus_rd;
        oe_v[h]  = ad_oe;
        if (h < 2 && ad_o !== a) adr_bad = 1'b1;
        if (wr && h >= 2 && h < 2 * ncyc && ad_o !== dv) dat_bad = 1'b1;
        if (bus_rd) ad_i = rv;
        if (iram_sel) iram_seen = 1'b1;
    endtask

    // Called at rise+2ns; returns at rise+2ns of a later cycle
    task automatic ext_txn(input bit wr, input logic [15:0] a, input logic [7:0] d,
                           input logic [1:0] code, input bit flip);
        int w, ncyc;
        logic [7:0] rv;
        logic [9:0] we_e, rd_e, oe_e;
        w    = (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 3;
        ncyc = wr ? (5 + w) / 2 : 3;
        rv   = ext_model(a);
        cpu_req = 1'b1; cpu_we = wr; cpu_addr = a; cpu_wdata = d;
        cfg_we_width = code; ad_i = 8'hEE;
        ale_v = '0; we_v = '0; rd_v = '0; oe_v = '0; rdy_v = '0;
        adr_bad = 1'b0; dat_bad = 1'b0; iram_seen = 1'b0; got_rdata = '0;
        @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(posedge clk);
            #2;
            grab(2 * k, a, {8'h00, d}, wr, ncyc, rv);
            rdy_v[k] = cpu_ready;
            if (cpu_ready) got_rdata = cpu_rdata;
            if (k == 0 && flip) cfg_we_width = ~code;
            if (k == ncyc) cpu_req = 1'b0;
            #4;
            grab(2 * k + 1, a, {8'h00, d}, wr, ncyc, rv);
        end
        we_e = '0; rd_e = '0; oe_e = '0;
        for (int h = 0; h < 10; h++) begin
            if (wr && h >= 3 && h <= 2 + w) we_e[h] = 1'b1;
            if (!wr && h >= 3 && h <= 5) rd_e[h] = 1'b1;
            if (h < 2 || (wr && h < 2 * ncyc)) oe_e[h] = 1'b1;
        end
        check("R2 latch strobe halves", 32'(ale_v), 32'h1);
        check(flip ? "R4 R10 write strobe halves" : "R4 write strobe halves",
              32'(we_v), 32'(we_e));
        check("R5 read strobe halves", 32'(rd_v), 32'(rd_e));
        check("R1 R3 R5 pin direction halves", 32'(oe_v), 32'(oe_e));
        check("R1 address on pins", 32'(adr_bad), 32'h0);
        if (wr) check("R3 data on pins", 32'(dat_bad), 32'h0);
        check("R6 ready cycle", 32'(rdy_v), 32'(5'd1 << ncyc));
        if (!wr) check("R6 read byte", 32'(got_rdata), 32'(rv));
        check("R8 on-die RAM idle", 32'(iram_seen), 32'h0);
        @(posedge clk); #2;
    endtask

    // Called at rise+2ns; returns at rise+2ns of a later cycle
    task automatic int_txn(input bit wr, input logic [15:0] a, input logic [7:0] d);
        cpu_req = 1'b1; cpu_we = wr; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #2;
        check("R7 ready with window hit", 32'(cpu_ready), 32'h1);
        check("R7 RAM select", 32'(iram_sel), 32'h1);
        check("R7 RAM write enable", 32'(iram_we), 32'(wr));
        check("R7 RAM address", 32'(iram_addr), 32'(a[11:0]));
        if (wr) check("R7 RAM write byte", 32'(iram_wdata), 32'(d));
        else    check("R7 RAM read byte", 32'(cpu_rdata), 32'(iram_model(a[11:0])));
        check("R7 pins idle first half", 32'({ad_oe, bus_ale, bus_rd, bus_we}), 32'h0);
        cpu_req = 1'b0;
        #4;
        check("R7 pins idle second half", 32'({ad_oe, bus_ale, bus_rd, bus_we}), 32'h0);
        @(posedge clk); #2;
        check("R6 ready single cycle", 32'({cpu_ready, iram_sel}), 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [15:0] a;
        int unused_seed;
        unused_seed = $urandom(32'd1873);
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
        cpu_wdata = '0; cfg_we_width = 2'd0; ad_i = 8'hEE;
        repeat (4) @(posedge clk);
        #2;
        check("R9 reset outputs", 32'({bus_ale, bus_rd, bus_we, ad_oe, cpu_ready, iram_sel}), 32'h0);
        check("R9 reset pins", 32'(ad_o), 32'h0);
        #4;
        check("R9 reset second half", 32'({bus_ale, bus_rd, bus_we}), 32'h0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(posedge clk); #2;

        // Window edges
        int_txn(1'b0, 16'h0000, 8'h00);
        int_txn(1'b1, 16'h0FFF, 8'h3C);
        int_txn(1'b0, 16'h0FFF, 8'h00);
        ext_txn(1'b0, 16'h1000, 8'h00, 2'd0, 1'b0);
        ext_txn(1'b1, 16'h1000, 8'hA7, 2'd1, 1'b0);
        // All width codes at the top address
        for (int c = 0; c < 4; c++) ext_txn(1'b1, 16'hFFFF, 8'h81, 2'(c), 1'b0);
        // Setting changed mid-transaction
        ext_txn(1'b1, 16'h8000, 8'h5E, 2'd0, 1'b1);
        ext_txn(1'b1, 16'h8001, 8'h19, 2'd3, 1'b1);
        ext_txn(1'b0, 16'hFFFF, 8'h00, 2'd2, 1'b1);

        // Seeded random mix
        for (int i = 0; i < 80; i++) begin
            a = 16'($urandom);
            if ($urandom % 4 == 0) a = a & 16'h0FFF;
            if (a < 16'h1000)
                int_txn(1'($urandom), a, 8'($urandom));
            else
                ext_txn(1'($urandom), a, 8'($urandom), 2'($urandom), ($urandom % 4) == 0);
        end
        summary();
    end
endmodule